// File: doc/BRIEF.md
# Clock-loss recovery controller

This block decides how the device reacts when its oscillator clock disappears while it sits in a low-power pseudo stop state. Three enable inputs select the reaction. With the monitor off, the loss goes unnoticed. With the monitor on and the self-clock fallback off, the block asks for a monitor reset at once. With both on, the block powers the regulator and the PLL, switches to a self-clock mode and raises an interrupt flag. It then runs a quality check that must see the oscillator healthy for 4096 consecutive oscillator ticks.

The later exit from pseudo stop depends on whether the quality check has passed. A wakeup or an external reset after recovery leaves pseudo stop on the oscillator. A wakeup or an external reset before recovery leaves pseudo stop still in self-clock mode, running from the PLL. In that case checking goes on for as long as the oscillator stays bad. The analog oscillator, PLL, regulator and loss detector are outside the block, and they appear only as input and output signals.

Top module: `clkloss_rcvr`

## Requirements
- R1: After reset, all outputs are 0: regulator and PLL enables, self-clock flag, clock select, pseudo-stop indication, interrupt flag, interrupt, monitor reset and reset-sequence start.
- R2: A stop request in normal run sets `in_pstop` on the next cycle. A wakeup while in pseudo stop with no clock loss clears it on the next cycle, with `sysclk_sel` at 0.
- R3: With `mon_en` at 0, `cm_fail` in pseudo stop changes nothing. No reset request is made, self-clock mode stays off, the flag stays 0 and the block stays in pseudo stop.
- R4: With `mon_en` 1 and `scm_en` 0, `cm_fail` in pseudo stop gives a one-cycle `cm_rst_req` pulse on the next cycle, and the block returns to normal run.
- R5: With `mon_en` and `scm_en` both 1, `cm_fail` in pseudo stop sets `vreg_en`, `pll_en`, `scm_act` and `scm_flag` on the next cycle. `in_pstop` stays 1 and `sysclk_sel` stays 0.
- R6: `scm_irq` is 1 exactly when `scm_flag` is set and `scm_irq_en` is 1, updated one cycle after either changes.
- R7: Once `cm_fail` is low, the quality check passes on the 4096th `osc_tick`. On that edge `scm_act`, `pll_en` and `vreg_en` fall, and if the block was still in pseudo stop, it stays there.
- R8: `cm_fail` during a quality check restarts the count from zero, so another 4096 ticks are needed.
- R9: After recovery, a wakeup or external reset leaves pseudo stop with `sysclk_sel` = 0 (oscillator). An external reset also pulses `rst_seq_start` for one cycle.
- R10: Before recovery, a wakeup or external reset leaves pseudo stop with `sysclk_sel` = 1 (PLL) and `scm_act` = 1, and an external reset also pulses `rst_seq_start`. Checking then continues without limit while the oscillator is bad. A later pass sets `sysclk_sel` to 0 and clears `scm_act`.
- R11: `scm_flag` holds until a `flag_clr` pulse, which clears it on the next cycle. A set on the same cycle wins over the clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| mon_en | input | 1 | Clock monitor enable |
| scm_en | input | 1 | Self-clock fallback enable |
| scm_irq_en | input | 1 | Self-clock interrupt enable |
| cm_fail | input | 1 | Clock monitor reports oscillator loss |
| osc_tick | input | 1 | One strobe per oscillator cycle |
| pstop_req | input | 1 | Request to enter pseudo stop |
| wake_req | input | 1 | Wakeup request |
| ext_rst_req | input | 1 | External reset request |
| flag_clr | input | 1 | Write-one-to-clear pulse for the flag |
| vreg_en | output | 1 | Regulator enable |
| pll_en | output | 1 | PLL enable |
| scm_act | output | 1 | Self-clock mode active |
| sysclk_sel | output | 1 | System clock source: 0 oscillator, 1 PLL |
| in_pstop | output | 1 | Device held in pseudo stop |
| scm_flag | output | 1 | Self-clock interrupt flag |
| scm_irq | output | 1 | Self-clock wakeup interrupt |
| cm_rst_req | output | 1 | Monitor reset request pulse |
| rst_seq_start | output | 1 | Reset-sequence start pulse |

## Verification
The hardest cases to reach are the count restart inside a long quality check and the exit taken before recovery. Both need thousands of clean ticks, placed exactly relative to a clock-loss pulse or a wakeup. The stimulus holds `osc_tick` high for a counted number of cycles and places the event between two counted runs. It then samples one cycle before and one cycle after the expected 4096th tick, so an off-by-one error or a missed restart shows up at the ports.

// File: rtl/clkloss_pkg.sv
package clkloss_pkg;

  typedef enum logic [1:0] {
    ST_RUN      = 2'd0,
    ST_PSTOP    = 2'd1,
    ST_PSTOP_SC = 2'd2,
    ST_RUN_SC   = 2'd3
  } cl_state_e;

  typedef struct packed {
    logic vreg;
    logic pll;
    logic scm;
    logic sel;
    logic pstop;
  } cl_lvl_t;

  function automatic cl_lvl_t cl_decode(cl_state_e s);
    cl_lvl_t l;
    l = '0;
    case (s)
      ST_PSTOP:    l.pstop = 1'b1;
      ST_PSTOP_SC: begin
        l.vreg  = 1'b1;
        l.pll   = 1'b1;
        l.scm   = 1'b1;
        l.pstop = 1'b1;
      end
      ST_RUN_SC:   begin
        l.vreg = 1'b1;
        l.pll  = 1'b1;
        l.scm  = 1'b1;
        l.sel  = 1'b1;
      end
      default:     l = '0;
    endcase
    return l;
  endfunction

endpackage

// File: rtl/clkloss_qual_cnt.sv
module clkloss_qual_cnt #(
  parameter int unsigned QCHK_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic active,
  input  logic fail,
  input  logic tick,
  output logic qpass
);
  localparam int unsigned CW = (QCHK_CYCLES > 1) ? $clog2(QCHK_CYCLES) : 1;
  localparam logic [CW-1:0] LAST = CW'(QCHK_CYCLES - 1);

  logic [CW-1:0] cnt_q, cnt_d;
  logic          cnt_en;
  logic          at_last;

  assign cnt_en  = active & tick & ~fail;
  assign at_last = (cnt_q == LAST);
  assign qpass   = cnt_en & at_last;

  always_comb begin
    cnt_d = cnt_q;
    if (!active || fail) begin
      cnt_d = '0;
    end else if (cnt_en) begin
      cnt_d = at_last ? '0 : cnt_q + CW'(1);
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else begin
      cnt_q <= cnt_d;
    end
  end
endmodule

// File: rtl/clkloss_flag.sv
module clkloss_flag (
  input  logic clk,
  input  logic rst_n,
  input  logic set,
  input  logic clr,
  input  logic irq_en,
  output logic flag,
  output logic irq
);
  logic flag_q, flag_d;
  logic irq_q, irq_d;

  always_comb begin
    flag_d = flag_q;
    if (set) begin
      flag_d = 1'b1;
    end else if (clr) begin
      flag_d = 1'b0;
    end
    irq_d = flag_d & irq_en;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      flag_q <= 1'b0;
      irq_q  <= 1'b0;
    end else begin
      flag_q <= flag_d;
      irq_q  <= irq_d;
    end
  end

  assign flag = flag_q;
  assign irq  = irq_q;
endmodule

// File: rtl/clkloss_fsm.sv
module clkloss_fsm
  import clkloss_pkg::*;
(
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic scm_en,
  input  logic cm_fail,
  input  logic pstop_req,
  input  logic wake_req,
  input  logic ext_rst_req,
  input  logic qpass,
  output logic flag_set,
  output logic vreg_en,
  output logic pll_en,
  output logic scm_act,
  output logic sysclk_sel,
  output logic in_pstop,
  output logic cm_rst_req,
  output logic rst_seq_start
);
  cl_state_e state_q, state_d;
  cl_lvl_t   lvl_q, lvl_d;
  logic      cmrst_q, cmrst_d;
  logic      rseq_q, rseq_d;
  logic      exit_req;

  assign exit_req = wake_req | ext_rst_req;

  always_comb begin
    state_d  = state_q;
    cmrst_d  = 1'b0;
    flag_set = 1'b0;
    rseq_d   = ext_rst_req;
    case (state_q)
      ST_RUN: begin
        if (pstop_req) state_d = ST_PSTOP;
      end
      ST_PSTOP: begin
        if (exit_req) begin
          state_d = ST_RUN;
        end else if (cm_fail && mon_en) begin
          if (scm_en) begin
            state_d  = ST_PSTOP_SC;
            flag_set = 1'b1;
          end else begin
            state_d = ST_RUN;
            cmrst_d = 1'b1;
          end
        end
      end
      ST_PSTOP_SC: begin
        if (exit_req) begin
          state_d = qpass ? ST_RUN : ST_RUN_SC;
        end else if (qpass) begin
          state_d = ST_PSTOP;
        end
      end
      ST_RUN_SC: begin
        if (qpass) state_d = ST_RUN;
      end
      default: state_d = ST_RUN;
    endcase
    lvl_d = cl_decode(state_d);
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      state_q <= ST_RUN;
      lvl_q   <= '0;
      cmrst_q <= 1'b0;
      rseq_q  <= 1'b0;
    end else begin
      state_q <= state_d;
      lvl_q   <= lvl_d;
      cmrst_q <= cmrst_d;
      rseq_q  <= rseq_d;
    end
  end

  assign vreg_en       = lvl_q.vreg;
  assign pll_en        = lvl_q.pll;
  assign scm_act       = lvl_q.scm;
  assign sysclk_sel    = lvl_q.sel;
  assign in_pstop      = lvl_q.pstop;
  assign cm_rst_req    = cmrst_q;
  assign rst_seq_start = rseq_q;
endmodule

// File: rtl/clkloss_rcvr.sv
module clkloss_rcvr #(
  parameter int unsigned QCHK_CYCLES = 4096
) (
  input  logic clk,
  input  logic rst_n,
  input  logic mon_en,
  input  logic scm_en,
  input  logic scm_irq_en,
  input  logic cm_fail,
  input  logic osc_tick,
  input  logic pstop_req,
  input  logic wake_req,
  input  logic ext_rst_req,
  input  logic flag_clr,
  output logic vreg_en,
  output logic pll_en,
  output logic scm_act,
  output logic sysclk_sel,
  output logic in_pstop,
  output logic scm_flag,
  output logic scm_irq,
  output logic cm_rst_req,
  output logic rst_seq_start
);
  logic qpass;
  logic flag_set;

  clkloss_qual_cnt #(.QCHK_CYCLES(QCHK_CYCLES)) qual_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .active (scm_act),
    .fail   (cm_fail),
    .tick   (osc_tick),
    .qpass  (qpass)
  );

  clkloss_fsm fsm_i (
    .clk           (clk),
    .rst_n         (rst_n),
    .mon_en        (mon_en),
    .scm_en        (scm_en),
    .cm_fail       (cm_fail),
    .pstop_req     (pstop_req),
    .wake_req      (wake_req),
    .ext_rst_req   (ext_rst_req),
    .qpass         (qpass),
    .flag_set      (flag_set),
    .vreg_en       (vreg_en),
    .pll_en        (pll_en),
    .scm_act       (scm_act),
    .sysclk_sel    (sysclk_sel),
    .in_pstop      (in_pstop),
    .cm_rst_req    (cm_rst_req),
    .rst_seq_start (rst_seq_start)
  );

  clkloss_flag flag_i (
    .clk    (clk),
    .rst_n  (rst_n),
    .set    (flag_set),
    .clr    (flag_clr),
    .irq_en (scm_irq_en),
    .flag   (scm_flag),
    .irq    (scm_irq)
  );
endmodule

// File: rtl/clkloss_rcvr_chk.sv
module clkloss_rcvr_chk (
  input logic clk,
  input logic rst_n,
  input logic mon_en,
  input logic scm_en,
  input logic scm_irq_en,
  input logic cm_fail,
  input logic osc_tick,
  input logic pstop_req,
  input logic wake_req,
  input logic ext_rst_req,
  input logic flag_clr,
  input logic vreg_en,
  input logic pll_en,
  input logic scm_act,
  input logic sysclk_sel,
  input logic in_pstop,
  input logic scm_flag,
  input logic scm_irq,
  input logic cm_rst_req,
  input logic rst_seq_start
);
  AST_SCM_POWERED: assert property (@(posedge clk) disable iff (!rst_n)
    scm_act |-> (vreg_en && pll_en)); // R5

  AST_PLL_SEL_NEEDS_SCM: assert property (@(posedge clk) disable iff (!rst_n)
    sysclk_sel |-> scm_act); // R10

  AST_NOMON_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (in_pstop && !scm_act && !mon_en) |=> (!cm_rst_req && !scm_act)); // R3

  AST_MONRST_ONE_CYCLE: assert property (@(posedge clk) disable iff (!rst_n)
    cm_rst_req |=> !cm_rst_req); // R4

  AST_IRQ_NEEDS_FLAG: assert property (@(posedge clk) disable iff (!rst_n)
    scm_irq |-> scm_flag); // R6

  AST_FLAG_HOLDS: assert property (@(posedge clk) disable iff (!rst_n)
    (scm_flag && !flag_clr) |=> scm_flag); // R11

  AST_EXIT_ON_OSC: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(scm_act) |-> !sysclk_sel); // R7
endmodule

bind clkloss_rcvr clkloss_rcvr_chk chk_i (.*);

// File: tb/clkloss_rcvr_tb.sv
module clkloss_rcvr_tb_top;
  logic clk;
  logic rst_n;
  logic mon_en, scm_en, scm_irq_en, cm_fail, osc_tick;
  logic pstop_req, wake_req, ext_rst_req, flag_clr;
  logic vreg_en, pll_en, scm_act, sysclk_sel, in_pstop;
  logic scm_flag, scm_irq, cm_rst_req, rst_seq_start;

  int checks = 0;
  int errors = 0;

  localparam int unsigned QN = 4096;

  clkloss_rcvr dut_i (
    .clk(clk), .rst_n(rst_n), .mon_en(mon_en), .scm_en(scm_en),
    .scm_irq_en(scm_irq_en), .cm_fail(cm_fail), .osc_tick(osc_tick),
    .pstop_req(pstop_req), .wake_req(wake_req), .ext_rst_req(ext_rst_req),
    .flag_clr(flag_clr), .vreg_en(vreg_en), .pll_en(pll_en),
    .scm_act(scm_act), .sysclk_sel(sysclk_sel), .in_pstop(in_pstop),
    .scm_flag(scm_flag), .scm_irq(scm_irq), .cm_rst_req(cm_rst_req),
    .rst_seq_start(rst_seq_start)
  );

  initial clk = 1'b0;
  always #10 clk = ~clk;

  task automatic chk(input string req, input string what, input logic act, input logic exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s %s actual=%b expected=%b", req, what, act, exp);
    end
  endtask

  task automatic cyc(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic do_reset();
    rst_n = 1'b0;
    mon_en = 0; scm_en = 0; scm_irq_en = 0; cm_fail = 0; osc_tick = 0;
    pstop_req = 0; wake_req = 0; ext_rst_req = 0; flag_clr = 0;
    cyc(2);
    rst_n = 1'b1;
    cyc(1);
  endtask

  task automatic enter_pstop();
    pstop_req = 1; cyc(1); pstop_req = 0;
  endtask

  task automatic lose_clock();
    cm_fail = 1; cyc(1); cm_fail = 0;
  endtask

  task automatic t_reset();
    do_reset();
    chk("R1", "vreg_en", vreg_en, 0);
    chk("R1", "pll_en", pll_en, 0);
    chk("R1", "scm_act", scm_act, 0);
    chk("R1", "sysclk_sel", sysclk_sel, 0);
    chk("R1", "in_pstop", in_pstop, 0);
    chk("R1", "scm_flag", scm_flag, 0);
    chk("R1", "scm_irq", scm_irq, 0);
    chk("R1", "cm_rst_req", cm_rst_req, 0);
    chk("R1", "rst_seq_start", rst_seq_start, 0);
  endtask

  task automatic t_enter_exit();
    do_reset();
    enter_pstop();
    chk("R2", "in_pstop after stop", in_pstop, 1);
    wake_req = 1; cyc(1); wake_req = 0;
    chk("R2", "in_pstop after wake", in_pstop, 0);
    chk("R2", "sysclk_sel after wake", sysclk_sel, 0);
    chk("R2", "rst_seq_start on wake", rst_seq_start, 0);
  endtask

  task automatic t_no_monitor();
    do_reset();
    scm_en = 1; scm_irq_en = 1;
    enter_pstop();
    cm_fail = 1; cyc(3); cm_fail = 0; cyc(1);
    chk("R3", "scm_act", scm_act, 0);
    chk("R3", "cm_rst_req", cm_rst_req, 0);
    chk("R3", "scm_flag", scm_flag, 0);
    chk("R3", "in_pstop", in_pstop, 1);
  endtask

  task automatic t_monitor_reset();
    do_reset();
    mon_en = 1;
    enter_pstop();
    lose_clock();
    chk("R4", "cm_rst_req pulse", cm_rst_req, 1);
    chk("R4", "in_pstop left", in_pstop, 0);
    chk("R4", "scm_act", scm_act, 0);
    cyc(1);
    chk("R4", "cm_rst_req one cycle", cm_rst_req, 0);
  endtask

  task automatic t_scm_entry_flag();
    do_reset();
    mon_en = 1; scm_en = 1;
    enter_pstop();
    lose_clock();
    chk("R5", "vreg_en", vreg_en, 1);
    chk("R5", "pll_en", pll_en, 1);
    chk("R5", "scm_act", scm_act, 1);
    chk("R5", "scm_flag", scm_flag, 1);
    chk("R5", "in_pstop", in_pstop, 1);
    chk("R5", "sysclk_sel", sysclk_sel, 0);
    chk("R6", "scm_irq masked", scm_irq, 0);
    scm_irq_en = 1; cyc(1);
    chk("R6", "scm_irq enabled", scm_irq, 1);
    cyc(5);
    chk("R11", "flag holds", scm_flag, 1);
    flag_clr = 1; cyc(1); flag_clr = 0;
    chk("R11", "flag cleared", scm_flag, 0);
    chk("R6", "scm_irq after clear", scm_irq, 0);
  endtask

  task automatic t_recover_then_wake(input logic use_rst);
    do_reset();
    mon_en = 1; scm_en = 1;
    enter_pstop();
    lose_clock();
    osc_tick = 1;
    cyc(QN - 1);
    chk("R7", "scm_act before last tick", scm_act, 1);
    cyc(1);
    chk("R7", "scm_act after pass", scm_act, 0);
    chk("R7", "pll_en after pass", pll_en, 0);
    chk("R7", "vreg_en after pass", vreg_en, 0);
    chk("R7", "in_pstop after pass", in_pstop, 1);
    osc_tick = 0;
    if (use_rst) begin
      ext_rst_req = 1; cyc(1); ext_rst_req = 0;
      chk("R9", "rst_seq_start", rst_seq_start, 1);
    end else begin
      wake_req = 1; cyc(1); wake_req = 0;
      chk("R9", "rst_seq_start on wake", rst_seq_start, 0);
    end
    chk("R9", "sysclk_sel oscillator", sysclk_sel, 0);
    chk("R9", "in_pstop exit", in_pstop, 0);
    chk("R9", "scm_act", scm_act, 0);
  endtask

  task automatic t_restart();
    do_reset();
    mon_en = 1; scm_en = 1;
    enter_pstop();
    lose_clock();
    osc_tick = 1;
    cyc(2000);
    cm_fail = 1; cyc(1); cm_fail = 0;
    chk("R8", "scm_act during fail", scm_act, 1);
    cyc(QN - 1);
    chk("R8", "no pass before full restart", scm_act, 1);
    cyc(1);
    chk("R8", "pass after full restart", scm_act, 0);
    osc_tick = 0;
  endtask

  task automatic t_exit_before_recovery(input logic use_rst);
    do_reset();
    mon_en = 1; scm_en = 1;
    enter_pstop();
    lose_clock();
    if (use_rst) begin
      ext_rst_req = 1; cyc(1); ext_rst_req = 0;
      chk("R10", "rst_seq_start", rst_seq_start, 1);
    end else begin
      wake_req = 1; cyc(1); wake_req = 0;
    end
    chk("R10", "sysclk_sel PLL", sysclk_sel, 1);
    chk("R10", "scm_act", scm_act, 1);
    chk("R10", "in_pstop left", in_pstop, 0);
    cm_fail = 1; osc_tick = 1; cyc(QN + 100);
    chk("R10", "checking continues while bad", sysclk_sel, 1);
    cm_fail = 0;
    cyc(QN - 1);
    chk("R10", "sel before pass", sysclk_sel, 1);
    cyc(1);
    chk("R10", "sel after pass", sysclk_sel, 0);
    chk("R10", "scm_act after pass", scm_act, 0);
    osc_tick = 0;
  endtask

  initial begin
    repeat (150000) @(posedge clk);
    checks++; errors++;
    $display("FAIL watchdog expired");
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end

  initial begin
    t_reset();
    t_enter_exit();
    t_no_monitor();
    t_monitor_reset();
    t_scm_entry_flag();
    t_recover_then_wake(1'b0);
    t_recover_then_wake(1'b1);
    t_restart();
    t_exit_before_recovery(1'b0);
    t_exit_before_recovery(1'b1);
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule